// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one 16-bit timer channel. A count clock enable (`tick`) advances it by one step. A load strobe stores a new initial count and a 3-bit operating mode at the same moment. The channel then produces its output waveform for the selected mode. The modes are terminal-count interrupt, gate-retriggered one-shot, periodic rate pulse, square wave, and two single-tick strobes (one started by software, one that the gate can retrigger). At all times the channel presents the value a host would read back or latch.

The channel measures elapsed counted ticks from the last restart and derives the output and the readable value from that measure. A restart is a load or, in the retriggerable modes, a rising gate edge. Depending on the mode, the gate either pauses counting while it is low or restarts counting on its rising edge. A separate one-cycle pulse marks every low-to-high change of the output so that an interrupt controller can count edges.

Top module: `interval_timer_ch`

## Requirements
- R1: After reset, `count_out` is 0 and both `out` and `out_rise` are 0.
- R2: In the clock cycle after `load` is high, `count_out` equals the loaded `load_value` and the elapsed count is 0. A `load` takes priority over a `tick` or a gate edge in the same cycle.
- R3: In modes 0 and 1, `out` is 0 until the elapsed count reaches the period N and is 1 from then on. `count_out` reads (N − elapsed) modulo 2^16, so it keeps wrapping below zero.
- R4: A `load_value` of 0 gives a period of 65536 ticks.
- R5: In modes 2 and 6, `out` is 1 only while the elapsed count is a nonzero multiple of N, up to the next counted tick. `count_out` reads N − (elapsed mod N).
- R6: In modes 3 and 7, `out` is 1 while (elapsed mod N) < (N+1)/2 (integer division) and 0 otherwise. `count_out` reads N − ((2·elapsed) mod N).
- R7: In modes 4 and 5, `out` is 1 only while the elapsed count equals N exactly. It is 0 before that and 0 after it.
- R8: In modes 0, 2, 3, 4, 6 and 7, a low `gate` makes `tick` have no effect: `count_out` and `out` hold their values. A rising gate edge in these modes does not restart counting.
- R9: In modes 1 and 5, the gate level does not stop counting. A rising `gate` edge sets the elapsed count back to 0, and that cycle's `tick` is not counted.
- R10: `out_rise` is high for exactly one cycle, the first cycle in which `out` is 1 after having been 0.
- R11: The mode is captured only when `load` is high. Changes on `mode` at other times have no effect on `out` or `count_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable, one elapsed step per high cycle |
| gate | input | 1 | Gate: level enable or retrigger, depending on mode |
| load | input | 1 | Strobe that stores `load_value` and `mode` and restarts counting |
| load_value | input | 16 | Initial count (0 means 65536) |
| mode | input | 3 | Operating mode, sampled with `load` |
| count_out | output | 16 | Current readable count |
| out | output | 1 | Channel output waveform |
| out_rise | output | 1 | One-cycle pulse on each rising edge of `out` |

## Verification
The phase, the doubled phase and the terminal flag are all held in registers, so a wrong value in any of them reaches the ports after a single counted tick. The readback is built directly from those registers. A phase that wraps too early or too late shifts the reloaded `count_out` value and the `out` edges by at least one tick within the first period. A terminal flag that is lost or set too soon changes `out` in modes 0, 1, 4 and 5 on the tick where the elapsed count reaches N. A mishandled gate shows up as a `count_out` that moves while it should hold, or that fails to jump back to N after a retrigger.

// File: rtl/itc_pkg.sv
package itc_pkg;

   typedef enum logic [1:0] {
      K_LATCH_END = 2'd0,
      K_PULSE_END = 2'd1,
      K_RATE      = 2'd2,
      K_SQUARE    = 2'd3
   } itc_kind_e;

   function automatic itc_kind_e kind_of(input logic [2:0] m);
      case (m)
         3'd0, 3'd1: kind_of = K_LATCH_END;
         3'd4, 3'd5: kind_of = K_PULSE_END;
         3'd2, 3'd6: kind_of = K_RATE;
         default:    kind_of = K_SQUARE;
      endcase
   endfunction

   function automatic logic edge_retrig(input logic [2:0] m);
      edge_retrig = (m == 3'd1) || (m == 3'd5);
   endfunction

endpackage

// File: rtl/itc_gate_ctrl.sv
module itc_gate_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic gate,
   input  logic retrig_mode,
   output logic restart,
   output logic count_en
);
   logic gate_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gate_q <= 1'b0;
      else        gate_q <= gate;
   end

   always_comb begin
      restart  = retrig_mode & gate & ~gate_q;
      count_en = retrig_mode | gate;
   end
endmodule

// File: rtl/itc_phase.sv
module itc_phase #(
   parameter int W = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          adv,
   input  logic          once,
   input  logic [W:0]    period,
   output logic [W:0]    ph,
   output logic [W:0]    ph2,
   output logic [W-1:0]  el,
   output logic          done,
   output logic          hit
);
   localparam int NW = W + 1;
   localparam logic [NW-1:0] ONE_N = NW'(1);
   localparam logic [NW:0]   TWO_X = (NW+1)'(2);
   localparam logic [W-1:0]  ONE_W = W'(1);

   logic [NW-1:0] ph_inc;
   logic          wrap;
   logic [NW:0]   t2, s1, s2, per_x;

   always_comb begin
      ph_inc = ph + ONE_N;
      wrap   = (ph_inc == period);
      per_x  = {1'b0, period};
      t2     = {1'b0, ph2} + TWO_X;
      s1     = (t2 >= per_x) ? (t2 - per_x) : t2;
      s2     = (s1 >= per_x) ? (s1 - per_x) : s1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph   <= '0;
         ph2  <= '0;
         el   <= '0;
         done <= 1'b0;
         hit  <= 1'b0;
      end else if (clr) begin
         ph   <= '0;
         ph2  <= '0;
         el   <= '0;
         done <= 1'b0;
         hit  <= 1'b0;
      end else if (adv) begin
         ph   <= wrap ? '0 : ph_inc;
         ph2  <= s2[NW-1:0];
         el   <= el + ONE_W;
         done <= done | wrap;
         hit  <= wrap & ~(once & done);
      end
   end

   // R3: terminal flag never drops without a restart
   a_r3_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !clr) |=> done);
   // R7: a terminal strobe lasts a single counted tick
   a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && once && adv && !clr) |=> !hit);
   // R5: phase stays inside the period
   a_r5_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
      ph < period);
   // R6: doubled phase stays inside the period
   a_r6_dbl_range: assert property (@(posedge clk) disable iff (!rst_n)
      ph2 < period);
endmodule

// File: rtl/itc_outgen.sv
module itc_outgen
   import itc_pkg::*;
#(
   parameter int W = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  itc_kind_e     kind,
   input  logic [W-1:0]  init_val,
   input  logic [W:0]    period,
   input  logic [W:0]    ph,
   input  logic [W:0]    ph2,
   input  logic [W-1:0]  el,
   input  logic          done,
   input  logic          hit,
   output logic [W-1:0]  count_out,
   output logic          out,
   output logic          out_rise
);
   localparam int NW = W + 1;
   localparam logic [NW:0] ONE_X = (NW+1)'(1);

   logic [NW:0]   half;
   logic [NW-1:0] rate_rd, sq_rd;
   logic          out_d;

   always_comb begin
      half    = ({1'b0, period} + ONE_X) >> 1;
      rate_rd = period - ph;
      sq_rd   = period - ph2;
      case (kind)
         K_LATCH_END: begin out = done; count_out = init_val - el; end
         K_PULSE_END: begin out = hit;  count_out = init_val - el; end
         K_RATE:      begin out = hit;  count_out = rate_rd[W-1:0]; end
         default:     begin out = ({1'b0, ph} < half); count_out = sq_rd[W-1:0]; end
      endcase
      out_rise = out & ~out_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_d <= 1'b0;
      else        out_d <= out;
   end

   // R10: rise marker is a single-cycle pulse
   a_r10_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
      out_rise |=> !out_rise);
endmodule

// File: rtl/interval_timer_ch.sv
module interval_timer_ch
   import itc_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             gate,
   input  logic             load,
   input  logic [WIDTH-1:0] load_value,
   input  logic [2:0]       mode,
   output logic [WIDTH-1:0] count_out,
   output logic             out,
   output logic             out_rise
);
   localparam int NW = WIDTH + 1;

   generate
      if (WIDTH < 2 || WIDTH > 30) begin : g_bad_width
         $error("interval_timer_ch: WIDTH must lie in 2..30");
      end
   endgenerate

   logic [WIDTH-1:0] init_q;
   logic [2:0]       mode_q;
   logic [NW-1:0]    period;
   logic             restart_w, en_w, adv_w, clr_w;
   logic [NW-1:0]    ph_w, ph2_w;
   logic [WIDTH-1:0] el_w;
   logic             done_w, hit_w;
   itc_kind_e        kind_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_q <= '0;
         mode_q <= 3'd0;
      end else if (load) begin
         init_q <= load_value;
         mode_q <= mode;
      end
   end

   always_comb begin
      period = {(init_q == '0), init_q};
      kind_w = kind_of(mode_q);
      clr_w  = load | restart_w;
      adv_w  = tick & en_w & ~clr_w;
   end

   itc_gate_ctrl u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .gate        (gate),
      .retrig_mode (edge_retrig(mode_q)),
      .restart     (restart_w),
      .count_en    (en_w)
   );

   itc_phase #(.W(WIDTH)) u_phase (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr_w),
      .adv    (adv_w),
      .once   (kind_w == K_PULSE_END),
      .period (period),
      .ph     (ph_w),
      .ph2    (ph2_w),
      .el     (el_w),
      .done   (done_w),
      .hit    (hit_w)
   );

   itc_outgen #(.W(WIDTH)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .kind      (kind_w),
      .init_val  (init_q),
      .period    (period),
      .ph        (ph_w),
      .ph2       (ph2_w),
      .el        (el_w),
      .done      (done_w),
      .hit       (hit_w),
      .count_out (count_out),
      .out       (out),
      .out_rise  (out_rise)
   );

   // R2: a load is visible at the readback on the next cycle
   a_r2_load_readback: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (count_out == $past(load_value)));
   // R8: with no counted tick and no restart, the ports hold
   a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !restart_w && !(tick && en_w)) |=> ($stable(count_out) && $stable(out)));
endmodule

// File: tb/interval_timer_ch_tb.sv
module interval_timer_ch_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        tick, gate, load;
   logic [15:0] load_value;
   logic [2:0]  mode;
   logic [15:0] count_out;
   logic        out, out_rise;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   interval_timer_ch u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate), .load(load),
      .load_value(load_value), .mode(mode),
      .count_out(count_out), .out(out), .out_rise(out_rise)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic report();
      $display("test done: total=%0d bad=%0d", checks, fails);
   endtask

   // expected values from the requirement formulas
   function automatic int ecnt(input int m, input int n, input int d);
      if (m == 0 || m == 1 || m == 4 || m == 5) return (n - d) & 'hffff;
      if (m == 2 || m == 6) return (n - (d % n)) & 'hffff;
      return (n - ((2 * d) % n)) & 'hffff;
   endfunction

   function automatic int eout(input int m, input int n, input int d);
      if (m == 0 || m == 1) return (d >= n) ? 1 : 0;
      if (m == 4 || m == 5) return (d == n) ? 1 : 0;
      if (m == 2 || m == 6) return (d != 0 && (d % n) == 0) ? 1 : 0;
      return ((d % n) < ((n + 1) / 2)) ? 1 : 0;
   endfunction

   task automatic cyc(input logic t);
      tick = t;
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic ldv(input int m, input int v, input logic t);
      mode = m[2:0]; load_value = v[15:0]; load = 1'b1; tick = t;
      @(negedge clk);
      load = 1'b0; tick = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", "count", count_out, 0);
      chk("R1", "out", out, 0);
      chk("R1", "rise", out_rise, 0);
   endtask

   task automatic t_mode(input string req, input int m, input int v, input int len);
      int n = (v == 0) ? 65536 : v;
      ldv(m, v, 1'b0);
      for (int d = 0; d <= len; d++) begin
         if (d < 4 || d > len - 3) begin
            chk(req, "count", count_out, ecnt(m, n, d));
            chk(req, "out", out, eout(m, n, d));
            if (d > 0)
               chk("R10", "rise", out_rise,
                   (eout(m, n, d) == 1 && eout(m, n, d - 1) == 0) ? 1 : 0);
         end
         if (d < len) cyc(1'b1);
      end
   endtask

   task automatic t_gate_level();
      ldv(0, 5, 1'b0);
      cyc(1); cyc(1);
      chk("R8", "count before pause", count_out, 3);
      gate = 1'b0;
      cyc(1); cyc(1); cyc(1);
      chk("R8", "count paused", count_out, 3);
      chk("R8", "out paused", out, 0);
      gate = 1'b1;
      cyc(1);
      chk("R8", "no restart on edge", count_out, 2);
      cyc(1); cyc(1);
      chk("R8", "count resumed", count_out, 0);
      chk("R8", "out resumed", out, 1);
      ldv(3, 4, 1'b0);
      cyc(1);
      chk("R8", "square count", count_out, 2);
      gate = 1'b0;
      cyc(1); cyc(1);
      chk("R8", "square paused count", count_out, 2);
      chk("R8", "square paused out", out, 1);
      gate = 1'b1;
      cyc(1);
      chk("R8", "square resumed count", count_out, 4);
      chk("R8", "square resumed out", out, 0);
   endtask

   task automatic t_retrig();
      ldv(1, 4, 1'b0);
      for (int i = 0; i < 5; i++) cyc(1);
      chk("R9", "count past end", count_out, 'hffff);
      chk("R9", "out latched", out, 1);
      gate = 1'b0;
      cyc(1);
      chk("R9", "low gate still counts", count_out, 'hfffe);
      gate = 1'b1;
      cyc(1);
      chk("R9", "restart count", count_out, 4);
      chk("R9", "restart out", out, 0);
      for (int i = 0; i < 4; i++) cyc(1);
      chk("R9", "end after restart", out, 1);
      ldv(5, 2, 1'b0);
      cyc(1); cyc(1);
      chk("R9", "strobe", out, 1);
      cyc(1);
      chk("R9", "strobe ends", out, 0);
      gate = 1'b0; cyc(0);
      gate = 1'b1; cyc(0);
      chk("R9", "hw strobe restart count", count_out, 2);
      cyc(1); cyc(1);
      chk("R9", "strobe again", out, 1);
   endtask

   task automatic t_load_prio();
      ldv(2, 7, 1'b0);
      cyc(1); cyc(1);
      chk("R2", "count before reload", count_out, 5);
      ldv(3, 3, 1'b1);
      chk("R2", "load wins over tick", count_out, 3);
      chk("R2", "new mode out", out, 1);
   endtask

   task automatic t_mode_capture();
      ldv(0, 4, 1'b0);
      mode = 3'd3;
      cyc(1);
      chk("R11", "count ignores mode pin", count_out, 3);
      chk("R11", "out ignores mode pin", out, 0);
      mode = 3'd0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      report();
      $finish;
   end

   initial begin
      rst_n = 1'b0; tick = 1'b0; gate = 1'b1; load = 1'b0;
      load_value = '0; mode = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mode("R3", 0, 5, 8);
      t_mode("R3", 0, 2, 5);
      t_mode("R3", 1, 3, 5);
      t_mode("R5", 2, 4, 10);
      t_mode("R5", 2, 1, 3);
      t_mode("R5", 6, 3, 7);
      t_mode("R6", 3, 6, 13);
      t_mode("R6", 3, 5, 11);
      t_mode("R6", 7, 4, 9);
      t_mode("R7", 4, 3, 6);
      t_mode("R7", 5, 2, 4);
      t_mode("R4", 2, 0, 65537);
      t_gate_level();
      t_retrig();
      t_load_prio();
      t_mode_capture();
      report();
      $finish;
   end
endmodule